// File: doc/BRIEF.md
# DAC Output Gate and Control Registers

This block sits between a host register port and eight digital-to-analog converter code buses. It keeps one 14-bit code register per channel and a 32-bit gate control word. The control word carries two host-writable bits: a load-inhibit bit and an output-enable bit. Together they decide what each output bus shows. When enable is set and load-inhibit is clear, the outputs track the code registers. When enable is clear, every output is driven to the mid-scale ground code. When both bits are set, the outputs freeze at whatever they last showed.

The block also holds a 32-bit interrupt control/status word. Only its low eleven bits can be written, and two of those bits are always forced on. The host writes the two 32-bit words through a configuration port and the 14-bit codes through a 16-bit data port. Reads on both ports are combinational from the stored state.

Configuration map: the interrupt word is at offset 0x00 and the gate control word is at offset 0x04. Code register i sits at data offset 0x10 + 2*i, for i = 0..7.

Top module: `dacg_top`

## Requirements
- R1: After reset, every code register reads 0x3FFF and every output bus carries 0x3FFF. The gate control word reads 0x060006C0, so enable (bit 26) is 1 and load-inhibit (bit 23) is 0. The interrupt word reads 0x00000300.
- R2: A write to configuration offset 0x04 changes only bit 23 (load-inhibit) and bit 26 (enable). Every other bit keeps its value from 0x060006C0.
- R3: A write to configuration offset 0x00 stores the low 11 bits of the data ORed with 0x300. Bits 31..11 read 0.
- R4: A data-port write at offset 0x10 + 2*i stores data bits 13..0 in code register i. A write at any other offset, odd or at 0x20 and beyond, changes no code register and no output.
- R5: While enable is 1 and load-inhibit is 0, a code write moves that channel's output to the new code at the same clock edge. The other channels keep their values.
- R6: A control write that leaves enable 1 and load-inhibit 0 reloads all eight outputs from their code registers at the same edge.
- R7: While enable is 0, all outputs carry the ground code 0x2000. Code writes are still stored but do not appear on the outputs.
- R8: While enable is 1 and load-inhibit is 1, the outputs keep their last values even when code registers are written.
- R9: Configuration reads return the interrupt word at 0x00, the control word at 0x04 and zero elsewhere. Data-port reads return the addressed code register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_addr | input | 8 | Configuration word offset, for both write and read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| dac_wr | input | 1 | Code register write strobe |
| dac_addr | input | 8 | Code register offset, for both write and read |
| dac_wdata | input | 16 | Code write data; bits 13..0 are stored |
| dac_rdata | output | 16 | Code read data, combinational |
| dac_out | output | 112 | Eight 14-bit output codes; channel i sits in bits 14*i+13..14*i |

## Verification
Every write is taken at one rising edge. The stored register, and any output bus it affects, changes at that same edge, so each result is due one edge after the strobe is raised. Read data is combinational and needs no edge.

The bench raises strobes on the falling edge and samples on the following falling edge. That places each sample half a period after the edge that must have produced the result. Read checks set the address and sample a short delay later within the same low phase.

// File: rtl/dacg_pkg.sv
package dacg_pkg;
    localparam int          DACG_N_CH       = 8;
    localparam int          DACG_CODE_W     = 14;
    localparam int          DACG_BUS_W      = 16;
    localparam int          DACG_ADDR_W     = 8;
    localparam int          DACG_REG_W      = 32;
    localparam int          DACG_LI_BIT     = 23;
    localparam int          DACG_EN_BIT     = 26;
    localparam logic [31:0] DACG_CTRL_RST   = 32'h0600_06C0;
    localparam logic [31:0] DACG_CTRL_WMASK = (32'h1 << DACG_LI_BIT) | (32'h1 << DACG_EN_BIT);
    localparam logic [31:0] DACG_IRQ_RST    = 32'h0000_0300;
    localparam logic [31:0] DACG_IRQ_WMASK  = 32'h0000_07FF;
    localparam logic [7:0]  DACG_IRQ_ADDR   = 8'h00;
    localparam logic [7:0]  DACG_CTRL_ADDR  = 8'h04;
    localparam logic [7:0]  DACG_CODE_BASE  = 8'h10;
    localparam logic [13:0] DACG_GND_CODE   = 14'h2000;
    localparam logic [13:0] DACG_CODE_RST   = 14'h3FFF;

    typedef struct packed {
        logic [DACG_REG_W-1:0] ctrl;
        logic [DACG_REG_W-1:0] irq;
    } cfg_state_t;
endpackage

// File: rtl/dacg_cfg_regs.sv
module dacg_cfg_regs
    import dacg_pkg::*;
#(
    parameter int          ADDR_W     = DACG_ADDR_W,
    parameter logic [31:0] CTRL_RST   = DACG_CTRL_RST,
    parameter logic [31:0] CTRL_WMASK = DACG_CTRL_WMASK,
    parameter logic [31:0] IRQ_RST    = DACG_IRQ_RST,
    parameter logic [31:0] IRQ_WMASK  = DACG_IRQ_WMASK,
    parameter logic [7:0]  IRQ_ADDR   = DACG_IRQ_ADDR,
    parameter logic [7:0]  CTRL_ADDR  = DACG_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [31:0]       ctrl_d,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       irq_q
);
    localparam logic [ADDR_W-1:0] IRQ_A  = ADDR_W'(IRQ_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && addr == CTRL_A) begin
            // writable bits come from the bus, the rest are pinned to reset values
            st_d.ctrl = (wdata & CTRL_WMASK) | (CTRL_RST & ~CTRL_WMASK);
        end
        if (wr && addr == IRQ_A) begin
            st_d.irq = (wdata & IRQ_WMASK) | IRQ_RST;
        end
    end

    always_comb begin
        if (addr == CTRL_A)      rdata = st_q.ctrl;
        else if (addr == IRQ_A)  rdata = st_q.irq;
        else                     rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
            st_q.irq  <= IRQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_d = st_d.ctrl;
    assign ctrl_q = st_q.ctrl;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/dacg_code_bank.sv
module dacg_code_bank
    import dacg_pkg::*;
#(
    parameter int          N_CH     = DACG_N_CH,
    parameter int          CODE_W   = DACG_CODE_W,
    parameter int          BUS_W    = DACG_BUS_W,
    parameter int          ADDR_W   = DACG_ADDR_W,
    parameter logic [7:0]  BASE     = DACG_CODE_BASE,
    parameter logic [13:0] CODE_RST = DACG_CODE_RST
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BUS_W-1:0]         wdata,
    output logic [BUS_W-1:0]         rdata,
    output logic [N_CH*CODE_W-1:0]   code_d,
    output logic [N_CH*CODE_W-1:0]   code_q
);
    localparam int STRIDE = BUS_W / 8;

    typedef struct packed {
        logic [N_CH-1:0][CODE_W-1:0] code;
    } bank_t;

    bank_t             st_d, st_q;
    logic [N_CH-1:0]   sel;
    logic              unused_hi;

    assign unused_hi = ^wdata[BUS_W-1:CODE_W];

    for (genvar g = 0; g < N_CH; g++) begin : g_dec
        assign sel[g] = (addr == ADDR_W'(int'(BASE) + STRIDE * g));
    end

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (wr && sel[i]) st_d.code[i] = wdata[CODE_W-1:0];
            if (sel[i])       rdata = BUS_W'(st_q.code[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) st_q.code[i] <= CODE_W'(CODE_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign code_d = st_d.code;
    assign code_q = st_q.code;
endmodule

// File: rtl/dacg_out_stage.sv
module dacg_out_stage
    import dacg_pkg::*;
#(
    parameter int          N_CH     = DACG_N_CH,
    parameter int          CODE_W   = DACG_CODE_W,
    parameter logic [13:0] GND_CODE = DACG_GND_CODE,
    parameter logic [13:0] OUT_RST  = DACG_CODE_RST
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_d,
    input  logic                   li_d,
    input  logic [N_CH*CODE_W-1:0] code_d,
    output logic [N_CH*CODE_W-1:0] out_q
);
    typedef struct packed {
        logic [N_CH-1:0][CODE_W-1:0] out;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_d) begin
            for (int i = 0; i < N_CH; i++) st_d.out[i] = CODE_W'(GND_CODE);
        end else if (!li_d) begin
            // tracking: each bus takes its code as it will stand after this edge
            st_d.out = code_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) st_q.out[i] <= CODE_W'(OUT_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q = st_q.out;
endmodule

// File: rtl/dacg_top.sv
module dacg_top
    import dacg_pkg::*;
#(
    parameter int          N_CH       = DACG_N_CH,
    parameter int          CODE_W     = DACG_CODE_W,
    parameter int          BUS_W      = DACG_BUS_W,
    parameter int          ADDR_W     = DACG_ADDR_W,
    parameter int          LI_BIT     = DACG_LI_BIT,
    parameter int          EN_BIT     = DACG_EN_BIT,
    parameter logic [31:0] CTRL_RST   = DACG_CTRL_RST,
    parameter logic [31:0] CTRL_WMASK = DACG_CTRL_WMASK,
    parameter logic [31:0] IRQ_RST    = DACG_IRQ_RST,
    parameter logic [31:0] IRQ_WMASK  = DACG_IRQ_WMASK,
    parameter logic [13:0] GND_CODE   = DACG_GND_CODE,
    parameter logic [13:0] CODE_RST   = DACG_CODE_RST
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic                   dac_wr,
    input  logic [ADDR_W-1:0]      dac_addr,
    input  logic [BUS_W-1:0]       dac_wdata,
    output logic [BUS_W-1:0]       dac_rdata,
    output logic [N_CH*CODE_W-1:0] dac_out
);
    logic [31:0]            ctrl_d, ctrl_q, irq_q;
    logic [N_CH*CODE_W-1:0] code_d, code_q;

    dacg_cfg_regs #(
        .ADDR_W(ADDR_W), .CTRL_RST(CTRL_RST), .CTRL_WMASK(CTRL_WMASK),
        .IRQ_RST(IRQ_RST), .IRQ_WMASK(IRQ_WMASK),
        .IRQ_ADDR(DACG_IRQ_ADDR), .CTRL_ADDR(DACG_CTRL_ADDR)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .ctrl_d(ctrl_d), .ctrl_q(ctrl_q), .irq_q(irq_q)
    );

    dacg_code_bank #(
        .N_CH(N_CH), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
        .BASE(DACG_CODE_BASE), .CODE_RST(CODE_RST)
    ) bank_i (
        .clk(clk), .rst_n(rst_n), .wr(dac_wr), .addr(dac_addr),
        .wdata(dac_wdata), .rdata(dac_rdata),
        .code_d(code_d), .code_q(code_q)
    );

    dacg_out_stage #(
        .N_CH(N_CH), .CODE_W(CODE_W), .GND_CODE(GND_CODE), .OUT_RST(CODE_RST)
    ) out_i (
        .clk(clk), .rst_n(rst_n),
        .en_d(ctrl_d[EN_BIT]), .li_d(ctrl_d[LI_BIT]),
        .code_d(code_d), .out_q(dac_out)
    );
endmodule

// File: rtl/dacg_top_chk.sv
module dacg_top_chk #(
    parameter int          N_CH       = 8,
    parameter int          CODE_W     = 14,
    parameter int          LI_BIT     = 23,
    parameter int          EN_BIT     = 26,
    parameter logic [31:0] CTRL_RST   = 32'h0600_06C0,
    parameter logic [31:0] CTRL_WMASK = 32'h0480_0000,
    parameter logic [31:0] IRQ_RST    = 32'h0000_0300,
    parameter logic [31:0] IRQ_WMASK  = 32'h0000_07FF,
    parameter logic [13:0] GND_CODE   = 14'h2000
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_wr,
    input logic [31:0]            ctrl_q,
    input logic [31:0]            irq_q,
    input logic [N_CH*CODE_W-1:0] code_q,
    input logic [N_CH*CODE_W-1:0] out_q
);
    localparam logic [N_CH*CODE_W-1:0] ALL_GND = {N_CH{CODE_W'(GND_CODE)}};

    AST_CTRL_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q ^ CTRL_RST) & ~CTRL_WMASK) == 32'h0); // R2

    AST_IRQ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_q & IRQ_RST) == IRQ_RST) && ((irq_q & ~IRQ_WMASK) == 32'h0)); // R3

    AST_TRACK_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[EN_BIT] && !ctrl_q[LI_BIT]) |-> (out_q == code_q)); // R5

    AST_GROUND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[EN_BIT] |-> (out_q == ALL_GND)); // R7

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[EN_BIT] && ctrl_q[LI_BIT] && !cfg_wr) |=> $stable(out_q)); // R8
endmodule

bind dacg_top dacg_top_chk #(
    .N_CH(N_CH), .CODE_W(CODE_W), .LI_BIT(LI_BIT), .EN_BIT(EN_BIT),
    .CTRL_RST(CTRL_RST), .CTRL_WMASK(CTRL_WMASK),
    .IRQ_RST(IRQ_RST), .IRQ_WMASK(IRQ_WMASK), .GND_CODE(GND_CODE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ctrl_q(ctrl_q),
    .irq_q(irq_q), .code_q(code_q), .out_q(dac_out)
);

// File: tb/dacg_top_tb_top.sv
`timescale 1ns/1ps
module dacg_top_tb_top;
    localparam int N_CH = 8;
    localparam int CW   = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              dac_wr = 1'b0;
    logic [7:0]        dac_addr = '0;
    logic [15:0]       dac_wdata = '0;
    logic [15:0]       dac_rdata;
    logic [N_CH*CW-1:0] dac_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dacg_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dac_wr(dac_wr), .dac_addr(dac_addr), .dac_wdata(dac_wdata), .dac_rdata(dac_rdata),
        .dac_out(dac_out)
    );

    typedef struct packed {
        logic        is_cfg;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [2:0]  ch;
        logic [13:0] exp;
        logic [3:0]  req;
    } vec_t;

    // op, offset, data, observed channel, expected code, requirement number
    localparam vec_t VECS [12] = '{
        '{1'b0, 8'h10, 32'h0000_1234, 3'd0, 14'h1234, 4'd5}, // R5 track ch0
        '{1'b0, 8'h12, 32'h0000_C555, 3'd1, 14'h0555, 4'd4}, // R4 low 14 bits only
        '{1'b1, 8'h04, 32'h0480_0000, 3'd0, 14'h1234, 4'd8}, // R8 enter hold
        '{1'b0, 8'h10, 32'h0000_0111, 3'd0, 14'h1234, 4'd8}, // R8 write ignored on bus
        '{1'b1, 8'h04, 32'h0400_0000, 3'd0, 14'h0111, 4'd6}, // R6 reload
        '{1'b1, 8'h04, 32'h0000_0000, 3'd2, 14'h2000, 4'd7}, // R7 ground
        '{1'b0, 8'h14, 32'h0000_0777, 3'd2, 14'h2000, 4'd7}, // R7 stored not shown
        '{1'b1, 8'h04, 32'h0400_0000, 3'd2, 14'h0777, 4'd6}, // R6 reload after ground
        '{1'b0, 8'h11, 32'h0000_0AAA, 3'd0, 14'h0111, 4'd4}, // R4 odd offset ignored
        '{1'b0, 8'h20, 32'h0000_0BBB, 3'd7, 14'h3FFF, 4'd4}, // R4 past last ignored
        '{1'b0, 8'h1E, 32'h0000_0001, 3'd7, 14'h0001, 4'd5}, // R5 last channel
        '{1'b1, 8'h04, 32'h0080_0000, 3'd1, 14'h2000, 4'd7}  // R7 inhibit set, enable 0
    };

    function automatic logic [CW-1:0] chan(input int i);
        return dac_out[i*CW +: CW];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic dac_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        dac_wr = 1'b1; dac_addr = a; dac_wdata = d;
        @(negedge clk);
        dac_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a; #0.5; d = cfg_rdata;
    endtask

    task automatic dac_read(input logic [7:0] a, output logic [15:0] d);
        dac_addr = a; #0.5; d = dac_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r32;
        logic [15:0] r16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < N_CH; i++) chk("R1 out", 32'(chan(i)), 32'h3FFF);
        for (int i = 0; i < N_CH; i++) begin
            dac_read(8'(8'h10 + 2*i), r16); chk("R1 code", 32'(r16), 32'h3FFF);
        end
        cfg_read(8'h04, r32); chk("R1 ctrl", r32, 32'h0600_06C0);
        cfg_read(8'h00, r32); chk("R1 irq", r32, 32'h0000_0300);

        // table walk
        for (int v = 0; v < 12; v++) begin
            if (VECS[v].is_cfg) cfg_write(VECS[v].addr, VECS[v].data);
            else                dac_write(VECS[v].addr, VECS[v].data[15:0]);
            chk($sformatf("R%0d vec%0d", VECS[v].req, v), 32'(chan(VECS[v].ch)), 32'(VECS[v].exp));
        end

        // R5 single-channel update leaves others alone
        cfg_write(8'h04, 32'h0400_0000);
        dac_write(8'h16, 16'h0042);
        chk("R5 ch3", 32'(chan(3)), 32'h0042);
        chk("R5 ch2 kept", 32'(chan(2)), 32'h0777);
        chk("R5 ch7 kept", 32'(chan(7)), 32'h0001);

        // R4 ignored writes left code registers untouched
        dac_read(8'h10, r16); chk("R4 ch0 code", 32'(r16), 32'h0111);
        dac_read(8'h12, r16); chk("R4 ch1 code", 32'(r16), 32'h0555);
        dac_read(8'h1E, r16); chk("R9 ch7 code", 32'(r16), 32'h0001);
        dac_read(8'h11, r16); chk("R9 odd read", 32'(r16), 32'h0);

        // R2 masking
        cfg_write(8'h04, 32'hFFFF_FFFF);
        cfg_read(8'h04, r32); chk("R2 ones", r32, 32'h0680_06C0);
        cfg_write(8'h04, 32'h0000_0000);
        cfg_read(8'h04, r32); chk("R2 zeros", r32, 32'h0200_06C0);

        // R3 interrupt word
        cfg_write(8'h00, 32'hFFFF_FFFF);
        cfg_read(8'h00, r32); chk("R3 ones", r32, 32'h0000_07FF);
        cfg_write(8'h00, 32'h0000_0055);
        cfg_read(8'h00, r32); chk("R3 pattern", r32, 32'h0000_0355);
        cfg_write(8'h00, 32'h0000_0000);
        cfg_read(8'h00, r32); chk("R3 zeros", r32, 32'h0000_0300);

        // R9 unmapped configuration read
        cfg_read(8'h08, r32); chk("R9 unmapped", r32, 32'h0);

        // R7 all channels grounded while enable is 0
        for (int i = 0; i < N_CH; i++) chk("R7 all gnd", 32'(chan(i)), 32'h2000);

        done = 1'b1;
        finish_run();
    end
endmodule